// File: doc/BRIEF.md
# Power Monitor Serial Slave Interface

This block is the two-wire serial slave of a power monitor. It watches the clock and data lines, which it oversamples on a fast system clock. It filters out short spikes and finds start and stop conditions. It answers one 7-bit address. Five bits of that address are fixed and two come from strap inputs.

A written byte carries one of two things, chosen by its top bit:
- A conversion command. This goes to the conversion sequencer.
- A pointer to one of three extended registers. The byte that follows is stored in the register it points to.

A read returns one of three things, depending on the stored command:
- Packed voltage and current samples as three bytes.
- A single channel as two bytes.
- One status byte.

The block drives SDA only through an active-high pull-low enable. The open-drain pad and the analog decoding of the address strap are outside it. Measurement values are frozen when the read address is acknowledged, so every byte of one read comes from the same pair of results. A read is refused while the sequencer reports a one-shot conversion still pending.

Top module: `pmon_i2c_slave`

## Requirements
- R1: The slave acknowledges only an address whose seven upper bits equal 01011 followed by `strap_i[1:0]`. Bit 0 of the address byte is the direction: 0 is write and 1 is read. With strap 10 the write byte is 0x5C and the read byte is 0x5D. Any other address gets no acknowledge and changes no output.
- R2: An acknowledged write address followed directly by a stop changes no register output and produces no `cmd_wr_o` pulse.
- R3: The first data byte of a write with bit 7 = 0 stores bits 6..0 on `cmd_o` and pulses `cmd_wr_o` for one cycle. In the command, bits 0/1 enable voltage, bits 2/3 enable current, and bit 6 selects a status read.
- R4: A first data byte with bit 7 = 1 selects a register through its bits 1..0: 00 `alert_en_o`, 01 `alert_th_o`, 10 `ctrl_o`. The next byte is written there. Code 11 is acknowledged but writes nothing. After reset, `alert_th_o` is 0xFF and the other registers are 0. Further bytes in the same write are acknowledged and ignored.
- R5: With voltage and current both enabled and bit 6 clear, a read returns three bytes, in this order:
  1. V[11:4]
  2. I[11:4]
  3. {V[3:0], I[3:0]}
- R6: With exactly one channel enabled and bit 6 clear, a read returns two bytes: S[11:4], then {S[3:0], 4'b0000}. S is the enabled channel's sample.
- R7: With bit 6 set, or with no channel enabled, a read returns `status_i` as a single byte.
- R8: A read address is not acknowledged while `oneshot_busy_i` is high.
- R9: The measurement inputs are captured when the read address is acknowledged. Changes to them later in the same read do not alter the bytes returned.
- R10: A start or stop seen in any state abandons the byte in progress, and a partial byte writes nothing. A repeated start returns the block to address matching.
- R11: A pulse on SCL or SDA shorter than `FILT_LEN` system clocks has no effect on the protocol.
- R12: `sda_oe_o` changes only while the filtered SCL is low. The exception is the release forced by a start or stop. The slave pulls SDA low for the ninth clock of each byte it acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line as seen on the bus |
| strap_i | input | 2 | Two low address bits from the strap decoder |
| oneshot_busy_i | input | 1 | One-shot conversion pending; refuses reads |
| volt_i | input | 12 | Latest voltage sample |
| curr_i | input | 12 | Latest current sample |
| status_i | input | 8 | Status byte from the alert controller |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| cmd_o | output | 7 | Stored conversion command |
| cmd_wr_o | output | 1 | One-cycle pulse on a command write |
| alert_en_o | output | 8 | Alert-enable register |
| alert_th_o | output | 8 | Alert-threshold register |
| ctrl_o | output | 8 | Control register |

## Verification
Two functions can land on the same cycle.
- The freeze of the transmit buffer can meet the sequencer delivering a fresh result. The bench provokes this by changing the voltage and current inputs in the middle of a three-byte read. It then judges the later bytes against the values present at the address acknowledge.
- The read-address decision can meet the busy flag. The bench checks that a read attempted while busy gets no acknowledge. It also checks that the same read succeeds once the flag drops.

// File: rtl/pmon_i2c_pkg.sv
package pmon_i2c_pkg;

    localparam int SAMPLE_W = 12;
    localparam int N_EXT    = 3;
    localparam logic [4:0] ADDR_PREFIX = 5'b01011;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } link_state_e;

    typedef struct packed {
        logic [7:0] b0;
        logic [7:0] b1;
        logic [7:0] b2;
        logic [1:0] len;
    } tx_frame_t;

    function automatic tx_frame_t pack_frame(
        input logic [6:0]          cmd,
        input logic [SAMPLE_W-1:0] v,
        input logic [SAMPLE_W-1:0] c,
        input logic [7:0]          st
    );
        tx_frame_t f;
        logic v_on;
        logic i_on;
        v_on = cmd[0] | cmd[1];
        i_on = cmd[2] | cmd[3];
        f = '0;
        if (cmd[6] || !(v_on || i_on)) begin
            f.b0  = st;
            f.len = 2'd1;
        end else if (v_on && i_on) begin
            f.b0  = v[11:4];
            f.b1  = c[11:4];
            f.b2  = {v[3:0], c[3:0]};
            f.len = 2'd3;
        end else if (v_on) begin
            f.b0  = v[11:4];
            f.b1  = {v[3:0], 4'h0};
            f.len = 2'd2;
        end else begin
            f.b0  = c[11:4];
            f.b1  = {c[3:0], 4'h0};
            f.len = 2'd2;
        end
        return f;
    endfunction

    function automatic logic [7:0] frame_byte(input tx_frame_t f, input logic [1:0] idx);
        case (idx)
            2'd0:    return f.b0;
            2'd1:    return f.b1;
            default: return f.b2;
        endcase
    endfunction

    function automatic logic [7:0] ext_reset(input int idx);
        return (idx == 1) ? 8'hFF : 8'h00;
    endfunction

endpackage

// File: rtl/pmon_glitch_filter.sv
module pmon_glitch_filter #(
    parameter int FILT_LEN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);

    logic [1:0]       sync_q;
    logic [CNT_W-1:0] cnt_q;
    logic             clean_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= 2'b11;
            cnt_q   <= '0;
            clean_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            if (sync_q[1] == clean_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
                clean_q <= sync_q[1];
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign clean_o = clean_q;

    // R11: the clean level only moves after a full run of differing samples
    p_filter_run_r11: assert property (@(posedge clk) disable iff (rst)
        (clean_q != $past(clean_q)) |-> ($past(cnt_q) == CNT_W'(FILT_LEN - 1)));

endmodule

// File: rtl/pmon_cmd_regs.sv
module pmon_cmd_regs
    import pmon_i2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_valid_i,
    input  logic       wr_first_i,
    input  logic [7:0] wr_byte_i,
    output logic [6:0] cmd_o,
    output logic       cmd_wr_o,
    output logic [7:0] ext_o [N_EXT]
);
    logic [6:0]       cmd_q;
    logic             cmd_wr_q;
    logic [1:0]       ptr_q;
    logic             ptr_vld_q;
    logic [N_EXT-1:0] ext_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q     <= '0;
            cmd_wr_q  <= 1'b0;
            ptr_q     <= '0;
            ptr_vld_q <= 1'b0;
        end else begin
            cmd_wr_q <= 1'b0;
            if (wr_valid_i) begin
                if (wr_first_i) begin
                    if (!wr_byte_i[7]) begin
                        cmd_q     <= wr_byte_i[6:0];
                        cmd_wr_q  <= 1'b1;
                        ptr_vld_q <= 1'b0;
                    end else begin
                        ptr_q     <= wr_byte_i[1:0];
                        ptr_vld_q <= 1'b1;
                    end
                end else begin
                    ptr_vld_q <= 1'b0;
                end
            end
        end
    end

    for (genvar g = 0; g < N_EXT; g++) begin : g_ext
        logic [7:0] reg_q;
        assign ext_we[g] = wr_valid_i && !wr_first_i && ptr_vld_q && (ptr_q == 2'(g));
        always_ff @(posedge clk) begin
            if (rst)            reg_q <= ext_reset(g);
            else if (ext_we[g]) reg_q <= wr_byte_i;
        end
        assign ext_o[g] = reg_q;
    end

    assign cmd_o    = cmd_q;
    assign cmd_wr_o = cmd_wr_q;

    // R3: a command strobe carries the byte that arrived just before
    p_cmd_store_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_wr_q |-> (cmd_q == $past(wr_byte_i[6:0])));

    // R4: at most one destination is written per byte
    p_single_dest_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ext_we, wr_valid_i && wr_first_i && !wr_byte_i[7]}));

endmodule

// File: rtl/pmon_i2c_link.sv
module pmon_i2c_link
    import pmon_i2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] strap_i,
    input  logic       busy_i,
    input  tx_frame_t  frame_i,
    output logic       sda_oe_o,
    output logic       wr_valid_o,
    output logic       wr_first_o,
    output logic [7:0] wr_byte_o
);
    link_state_e state_q;
    logic        scl_d, sda_d;
    logic [3:0]  cnt_q;
    logic [7:0]  shreg_q;
    logic [7:0]  txsh_q;
    logic        rw_q, first_q, mack_q, sda_oe_q;
    logic        wr_valid_q, wr_first_q;
    logic [7:0]  wr_byte_q;
    logic [1:0]  byte_idx_q;
    tx_frame_t   frame_q;

    logic scl_rise, scl_fall, start_evt, stop_evt, addr_hit;
    logic [7:0] next_byte;

    assign scl_rise  = scl_i & ~scl_d;
    assign scl_fall  = ~scl_i & scl_d;
    assign start_evt = scl_i & scl_d & sda_d & ~sda_i;
    assign stop_evt  = scl_i & scl_d & ~sda_d & sda_i;
    assign addr_hit  = (shreg_q[7:1] == {ADDR_PREFIX, strap_i});
    assign next_byte = frame_byte(frame_q, byte_idx_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d      <= 1'b1;
            sda_d      <= 1'b1;
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            shreg_q    <= '0;
            txsh_q     <= '0;
            rw_q       <= 1'b0;
            first_q    <= 1'b0;
            mack_q     <= 1'b0;
            sda_oe_q   <= 1'b0;
            wr_valid_q <= 1'b0;
            wr_first_q <= 1'b0;
            wr_byte_q  <= '0;
            byte_idx_q <= '0;
            frame_q    <= '0;
        end else begin
            scl_d      <= scl_i;
            sda_d      <= sda_i;
            wr_valid_q <= 1'b0;
            if (start_evt) begin
                state_q  <= ST_ADDR;
                cnt_q    <= '0;
                sda_oe_q <= 1'b0;
            end else if (stop_evt) begin
                state_q  <= ST_IDLE;
                sda_oe_q <= 1'b0;
            end else begin
                case (state_q)
                    ST_ADDR, ST_WR_BYTE: begin
                        if (scl_rise && cnt_q != 4'd8) begin
                            shreg_q <= {shreg_q[6:0], sda_i};
                            cnt_q   <= cnt_q + 1'b1;
                        end else if (scl_fall && cnt_q == 4'd8) begin
                            if (state_q == ST_ADDR) begin
                                if (addr_hit && !(shreg_q[0] && busy_i)) begin
                                    sda_oe_q <= 1'b1;
                                    state_q  <= ST_ADDR_ACK;
                                    rw_q     <= shreg_q[0];
                                    first_q  <= 1'b1;
                                    if (shreg_q[0]) frame_q <= frame_i;
                                end else begin
                                    state_q <= ST_IDLE;
                                end
                            end else begin
                                sda_oe_q   <= 1'b1;
                                state_q    <= ST_WR_ACK;
                                wr_valid_q <= 1'b1;
                                wr_first_q <= first_q;
                                wr_byte_q  <= shreg_q;
                                first_q    <= 1'b0;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            if (rw_q) begin
                                state_q    <= ST_RD_BYTE;
                                sda_oe_q   <= ~frame_q.b0[7];
                                txsh_q     <= {frame_q.b0[6:0], 1'b0};
                                cnt_q      <= 4'd1;
                                byte_idx_q <= 2'd1;
                            end else begin
                                state_q  <= ST_WR_BYTE;
                                sda_oe_q <= 1'b0;
                                cnt_q    <= '0;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            sda_oe_q <= 1'b0;
                            state_q  <= ST_WR_BYTE;
                            cnt_q    <= '0;
                        end
                    end
                    ST_RD_BYTE: begin
                        if (scl_fall) begin
                            if (cnt_q != 4'd8) begin
                                sda_oe_q <= ~txsh_q[7];
                                txsh_q   <= {txsh_q[6:0], 1'b0};
                                cnt_q    <= cnt_q + 1'b1;
                            end else begin
                                sda_oe_q <= 1'b0;
                                state_q  <= ST_RD_ACK;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_i;
                        end else if (scl_fall) begin
                            if (mack_q && byte_idx_q < frame_q.len) begin
                                sda_oe_q   <= ~next_byte[7];
                                txsh_q     <= {next_byte[6:0], 1'b0};
                                cnt_q      <= 4'd1;
                                byte_idx_q <= byte_idx_q + 1'b1;
                                state_q    <= ST_RD_BYTE;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe_o   = sda_oe_q;
    assign wr_valid_o = wr_valid_q;
    assign wr_first_o = wr_first_q;
    assign wr_byte_o  = wr_byte_q;

    // R12: no SDA movement while SCL is high, apart from a bus-condition release
    p_sda_quiet_high_r12: assert property (@(posedge clk) disable iff (rst)
        ($past(scl_i) && !$past(start_evt || stop_evt)) |-> $stable(sda_oe_q));

    // R8: a read address during a pending one-shot is left unacknowledged
    p_busy_refuse_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ADDR && scl_fall && cnt_q == 4'd8 && shreg_q[0] && busy_i
         && !start_evt && !stop_evt) |=> !sda_oe_q);

    // R10: a start always lands in address matching with SDA released
    p_start_abort_r10: assert property (@(posedge clk) disable iff (rst)
        start_evt |=> (state_q == ST_ADDR && !sda_oe_q));

endmodule

// File: rtl/pmon_i2c_slave.sv
module pmon_i2c_slave
    import pmon_i2c_pkg::*;
#(
    parameter int FILT_LEN = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                scl_i,
    input  logic                sda_i,
    input  logic [1:0]          strap_i,
    input  logic                oneshot_busy_i,
    input  logic [SAMPLE_W-1:0] volt_i,
    input  logic [SAMPLE_W-1:0] curr_i,
    input  logic [7:0]          status_i,
    output logic                sda_oe_o,
    output logic [6:0]          cmd_o,
    output logic                cmd_wr_o,
    output logic [7:0]          alert_en_o,
    output logic [7:0]          alert_th_o,
    output logic [7:0]          ctrl_o
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] clean_lines;
    logic               wr_valid, wr_first;
    logic [7:0]         wr_byte;
    logic [7:0]         ext_regs [N_EXT];
    tx_frame_t          live_frame;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_filt
        pmon_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk     (clk),
            .rst     (rst),
            .raw_i   (raw_lines[g]),
            .clean_o (clean_lines[g])
        );
    end

    assign live_frame = pack_frame(cmd_o, volt_i, curr_i, status_i);

    pmon_i2c_link u_link (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (clean_lines[1]),
        .sda_i      (clean_lines[0]),
        .strap_i    (strap_i),
        .busy_i     (oneshot_busy_i),
        .frame_i    (live_frame),
        .sda_oe_o   (sda_oe_o),
        .wr_valid_o (wr_valid),
        .wr_first_o (wr_first),
        .wr_byte_o  (wr_byte)
    );

    pmon_cmd_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_valid_i (wr_valid),
        .wr_first_i (wr_first),
        .wr_byte_i  (wr_byte),
        .cmd_o      (cmd_o),
        .cmd_wr_o   (cmd_wr_o),
        .ext_o      (ext_regs)
    );

    assign alert_en_o = ext_regs[0];
    assign alert_th_o = ext_regs[1];
    assign ctrl_o     = ext_regs[2];

endmodule

// File: tb/sim_pmon_i2c_slave.sv
`timescale 1ns/1ps
module sim_pmon_i2c_slave;

    localparam int H = 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b1;
    logic        sda_drv = 1'b1;
    logic [1:0]  strap = 2'b10;
    logic        busy = 1'b0;
    logic [11:0] volt = '0;
    logic [11:0] curr = '0;
    logic [7:0]  status = '0;
    logic        sda_oe;
    logic [6:0]  cmd;
    logic        cmd_wr;
    logic [7:0]  alert_en, alert_th, ctrl;
    logic        sda_bus;

    int checks = 0;
    int errors = 0;
    int wr_pulses = 0;

    always #4 clk = ~clk;

    assign sda_bus = sda_drv & ~sda_oe;

    pmon_i2c_slave u0 (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .strap_i(strap),
        .oneshot_busy_i(busy), .volt_i(volt), .curr_i(curr), .status_i(status),
        .sda_oe_o(sda_oe), .cmd_o(cmd), .cmd_wr_o(cmd_wr),
        .alert_en_o(alert_en), .alert_th_o(alert_th), .ctrl_o(ctrl)
    );

    always @(posedge clk) if (cmd_wr) wr_pulses <= wr_pulses + 1;

    // {cmd, volt, curr, status, nbytes, expected bytes}
    localparam logic [67:0] VEC [6] = '{
        {8'h05, 12'hABC, 12'h123, 8'h00, 4'd3, 24'hAB12C3},
        {8'h01, 12'h5A7, 12'h999, 8'h00, 4'd2, 24'h5A7000},
        {8'h04, 12'h111, 12'hF0E, 8'h00, 4'd2, 24'hF0E000},
        {8'h42, 12'h777, 12'h888, 8'h3C, 4'd1, 24'h3C0000},
        {8'h00, 12'h777, 12'h888, 8'h81, 4'd1, 24'h810000},
        {8'h0A, 12'h001, 12'hFFF, 8'h00, 4'd3, 24'h00FF1F}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; w(H/2);
        scl = 1'b1; w(H);
        sda_drv = 1'b0; w(H);
        scl = 1'b0; w(H/2);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; w(H);
        scl = 1'b1; w(H);
        sda_drv = 1'b1; w(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n, input int gbit);
        for (int i = 7; i > 7 - n; i--) begin
            sda_drv = b[i];
            if (i == gbit) begin
                w(H/2); scl = 1'b1; w(4); scl = 1'b0; w(H/2);
            end else begin
                w(H);
            end
            scl = 1'b1; w(H);
            scl = 1'b0; w(H/2);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input int gbit, output logic ack);
        send_bits(b, 8, gbit);
        sda_drv = 1'b1; w(H);
        scl = 1'b1; w(H/2);
        ack = ~sda_bus; w(H/2);
        scl = 1'b0; w(H/2);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = 1'b1; w(H);
            scl = 1'b1; w(H/2);
            b[i] = sda_bus; w(H/2);
            scl = 1'b0; w(H/2);
        end
        sda_drv = ~mack; w(H);
        scl = 1'b1; w(H);
        scl = 1'b0; w(H/2);
        sda_drv = 1'b1;
    endtask

    task automatic write_one(input logic [7:0] b);
        logic a;
        bus_start(); send_byte(8'h5C, -1, a); send_byte(b, -1, a); bus_stop();
    endtask

    task automatic write_ext(input logic [7:0] p, input logic [7:0] d);
        logic a;
        bus_start(); send_byte(8'h5C, -1, a); send_byte(p, -1, a); send_byte(d, -1, a); bus_stop();
    endtask

    task automatic read_n(input int n, output logic ack, output logic [23:0] d);
        logic [7:0] b;
        d = '0;
        bus_start();
        send_byte(8'h5D, -1, ack);
        if (ack) begin
            for (int k = 0; k < n; k++) begin
                recv_byte(k < n - 1, b);
                d[23-8*k -: 8] = b;
            end
        end
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic        a;
        logic [23:0] d;
        logic [7:0]  b0, b1, b2;
        int          p0;

        w(5); rst = 1'b0; w(5);
        // reset state (R4 reset values, R12 released SDA)
        chk("R4 reset thresh", alert_th, 8'hFF);
        chk("R4 reset enable", alert_en, 8'h00);
        chk("R3 reset cmd", cmd, 7'h00);
        chk("R12 reset sda", sda_oe, 1'b0);

        // table walk: R3 command, R5/R6/R7 formats
        for (int k = 0; k < 6; k++) begin
            logic [67:0] v;
            v = VEC[k];
            write_one(v[67:60]);
            chk("R3 command stored", cmd, v[66:60]);
            volt = v[59:48]; curr = v[47:36]; status = v[35:28];
            read_n(int'(v[27:24]), a, d);
            chk("R12 read ack", a, 1'b1);
            chk("R5 R6 R7 read bytes", d, v[23:0]);
        end

        // R1: wrong strap and wrong prefix get no ack, state untouched
        bus_start(); send_byte(8'h58, -1, a); bus_stop();
        chk("R1 strap mismatch nack", a, 1'b0);
        bus_start(); send_byte(8'h1C, -1, a); bus_stop();
        chk("R1 prefix mismatch nack", a, 1'b0);
        bus_start(); send_byte(8'h5C, -1, a); bus_stop();
        chk("R1 matching address ack", a, 1'b1);

        // R2: quick command changes nothing
        p0 = wr_pulses;
        bus_start(); send_byte(8'h5C, -1, a); bus_stop();
        chk("R2 quick no pulse", wr_pulses - p0, 0);
        chk("R2 quick cmd kept", cmd, 7'h0A);

        // R4: extended writes and reserved code
        write_ext(8'h81, 8'h40);
        chk("R4 threshold", alert_th, 8'h40);
        write_ext(8'h80, 8'h13);
        chk("R4 alert enable", alert_en, 8'h13);
        write_ext(8'h82, 8'h01);
        chk("R4 control", ctrl, 8'h01);
        p0 = wr_pulses;
        write_ext(8'h83, 8'h77);
        chk("R4 reserved no change", {alert_en, alert_th, ctrl}, 24'h134001);
        chk("R4 reserved no cmd pulse", wr_pulses - p0, 0);

        // R11: short SCL glitch inside a byte is ignored
        write_one(8'h05);
        bus_start(); send_byte(8'h5C, -1, a); send_byte(8'h01, 3, a); bus_stop();
        chk("R11 glitch-free command", cmd, 7'h01);

        // R10: stop inside a partial byte writes nothing
        write_one(8'h05);
        bus_start(); send_byte(8'h5C, -1, a); send_bits(8'h00, 3, -1); bus_stop();
        chk("R10 stop abort", cmd, 7'h05);

        // R10: repeated start after a partial byte returns to address matching
        volt = 12'h9A3; curr = 12'h4B6;
        bus_start(); send_byte(8'h5C, -1, a); send_bits(8'h01, 3, -1);
        bus_start(); send_byte(8'h5D, -1, a);
        chk("R10 restart read ack", a, 1'b1);
        recv_byte(1'b1, b0); recv_byte(1'b1, b1); recv_byte(1'b0, b2); bus_stop();
        chk("R10 restart data", {b0, b1, b2}, 24'h9A4B36);
        chk("R10 restart cmd kept", cmd, 7'h05);

        // R8: busy refuses read, then allowed
        busy = 1'b1;
        read_n(3, a, d);
        chk("R8 busy nack", a, 1'b0);
        busy = 1'b0;
        read_n(3, a, d);
        chk("R8 idle ack", a, 1'b1);

        // R9: inputs change mid-read; bytes come from the captured pair
        volt = 12'h321; curr = 12'h654;
        bus_start(); send_byte(8'h5D, -1, a);
        recv_byte(1'b1, b0);
        volt = 12'hFFF; curr = 12'h000;
        recv_byte(1'b1, b1); recv_byte(1'b0, b2); bus_stop();
        chk("R9 snapshot", {b0, b1, b2}, 24'h326514);

        // R12: SDA released when idle after all transfers
        w(10);
        chk("R12 idle release", sda_oe, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule